// File: doc/BRIEF.md
# Vector Reorder-and-Select Unit

This block rearranges the lanes of one input vector under a per-lane index vector and then, lane by lane, chooses between the rearranged vector and a second operand. The second operand is either an incoming vector or a constant broadcast to every lane from a small built-in set: zero, one, minus one and None. Every lane carries a one-bit None flag next to its data, and the flag travels with the data through both steps.

The reorder step can only copy or duplicate existing lanes. It can never put a zero or a None into a lane. Those values enter only through the select step against a constant vector. Both steps are combinational and feed one result register. An issue strobe loads that register, and the result with its valid pulse appears one cycle after issue.

Top module: `vsp_unit`

## Requirements
- R1: Before selection, lane i of the reordered vector is a copy of source lane `idx[i*IW +: IW]`, where lane i of every data port occupies bits `[i*EW +: EW]` and IW = clog2(NLANES).
- R2: Several lanes may name the same source index, and each of those lanes then receives a copy of that source lane.
- R3: The reorder step carries each lane's None flag with its data and introduces no None of its own. When neither source has a None lane, the result has none.
- R4: For each lane i, `mask[i]` = 1 selects the reordered lane and `mask[i]` = 0 selects the second operand's lane.
- R5: With `use_const` = 0, the second operand is `b_data`/`b_none`.
- R6: With `use_const` = 1, the second operand is a constant in every lane, selected by `const_sel`: 0 is zero, 1 is one, 2 is all ones (minus one), 3 is None (data zero, flag set). Non-None constants have the flag clear, and `b_data`/`b_none` are ignored.
- R7: A high `issue` at a rising edge loads the result. The result and `res_valid` = 1 are visible after that edge, which is one cycle after issue.
- R8: With `issue` low, the result holds its value and `res_valid` is low after the next edge.
- R9: Synchronous reset sets every result lane to None with zero data and sets `res_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Load strobe for the result register |
| a_data | input | NLANES*EW | Source vector data |
| a_none | input | NLANES | Source vector None flags |
| idx | input | NLANES*IW | Per-lane reorder index |
| mask | input | NLANES | Per-lane select, 1 takes reordered lane |
| b_data | input | NLANES*EW | Second operand data |
| b_none | input | NLANES | Second operand None flags |
| use_const | input | 1 | 1 replaces the second operand with a constant |
| const_sel | input | 2 | Constant code |
| res_data | output | NLANES*EW | Registered result data |
| res_none | output | NLANES | Registered result None flags |
| res_valid | output | 1 | High for the cycle after an issue |

## Verification
The main function is tried with four index patterns: identity, reversal, full duplication and a broadcast of lane zero. Reversal exposes swapped lane numbering, and duplication exposes an index decoder that assumes a permutation. Masks of all ones, all zeros and alternating bits are paired with each of the four constants and with the incoming operand, which exposes an inverted mask or a wrong constant code. A source with a None lane that is duplicated across all lanes shows whether the flag travels with the data. Directed runs then cover reset, holding without issue, and reset after a load.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

    // Constant codes; the numeric value is the const_sel encoding.
    typedef enum logic [1:0] {
        CK_ZERO     = 2'd0,
        CK_ONE      = 2'd1,
        CK_ALL_ONES = 2'd2,
        CK_NONE     = 2'd3
    } const_kind_e;

    // Second operand source control.
    typedef struct packed {
        logic        use_const;
        const_kind_e kind;
    } opb_ctrl_t;

    function automatic logic kind_is_none(const_kind_e k);
        return (k == CK_NONE);
    endfunction

    function automatic int unsigned index_width(int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/vsp_shuffle.sv
module vsp_shuffle #(
    parameter int unsigned NLANES = 4,
    parameter int unsigned EW     = 8,
    localparam int unsigned IW    = vsp_pkg::index_width(NLANES)
) (
    input  logic [NLANES*EW-1:0] in_data,
    input  logic [NLANES-1:0]    in_none,
    input  logic [NLANES*IW-1:0] idx,
    output logic [NLANES*EW-1:0] out_data,
    output logic [NLANES-1:0]    out_none
);

    // One index-driven selector per output lane; only copies are possible.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [IW-1:0] src;
        assign src = idx[g*IW +: IW];
        assign out_data[g*EW +: EW] = in_data[src*EW +: EW];
        assign out_none[g]          = in_none[src];
    end

endmodule

// File: rtl/vsp_operand_b.sv
module vsp_operand_b #(
    parameter int unsigned NLANES = 4,
    parameter int unsigned EW     = 8
) (
    input  vsp_pkg::opb_ctrl_t   ctrl,
    input  logic [NLANES*EW-1:0] b_data,
    input  logic [NLANES-1:0]    b_none,
    output logic [NLANES*EW-1:0] op_data,
    output logic [NLANES-1:0]    op_none
);
    import vsp_pkg::*;

    logic [EW-1:0] k_scalar;
    logic          k_none;

    always_comb begin
        unique case (ctrl.kind)
            CK_ZERO:     k_scalar = '0;
            CK_ONE:      k_scalar = EW'(1);
            CK_ALL_ONES: k_scalar = '1;
            default:     k_scalar = '0;
        endcase
        k_none = kind_is_none(ctrl.kind);
    end

    // Broadcast the scalar constant to every lane, or pass the operand.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign op_data[g*EW +: EW] = ctrl.use_const ? k_scalar : b_data[g*EW +: EW];
        assign op_none[g]          = ctrl.use_const ? k_none   : b_none[g];
    end

endmodule

// File: rtl/vsp_pick.sv
module vsp_pick #(
    parameter int unsigned NLANES = 4,
    parameter int unsigned EW     = 8
) (
    input  logic [NLANES-1:0]    mask,
    input  logic [NLANES*EW-1:0] x_data,
    input  logic [NLANES-1:0]    x_none,
    input  logic [NLANES*EW-1:0] y_data,
    input  logic [NLANES-1:0]    y_none,
    output logic [NLANES*EW-1:0] out_data,
    output logic [NLANES-1:0]    out_none
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign out_data[g*EW +: EW] = mask[g] ? x_data[g*EW +: EW] : y_data[g*EW +: EW];
        assign out_none[g]          = mask[g] ? x_none[g]          : y_none[g];
    end

endmodule

// File: rtl/vsp_unit.sv
module vsp_unit #(
    parameter int unsigned NLANES = 4,
    parameter int unsigned EW     = 8,
    localparam int unsigned IW    = vsp_pkg::index_width(NLANES),
    localparam int unsigned VW    = NLANES * EW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [VW-1:0]     a_data,
    input  logic [NLANES-1:0] a_none,
    input  logic [NLANES*IW-1:0] idx,
    input  logic [NLANES-1:0] mask,
    input  logic [VW-1:0]     b_data,
    input  logic [NLANES-1:0] b_none,
    input  logic              use_const,
    input  logic [1:0]        const_sel,
    output logic [VW-1:0]     res_data,
    output logic [NLANES-1:0] res_none,
    output logic              res_valid
);
    import vsp_pkg::*;

    logic [VW-1:0]     shuf_data;
    logic [NLANES-1:0] shuf_none;
    logic [VW-1:0]     opb_data;
    logic [NLANES-1:0] opb_none;
    logic [VW-1:0]     pick_data;
    logic [NLANES-1:0] pick_none;
    opb_ctrl_t         opb_ctrl;

    assign opb_ctrl.use_const = use_const;
    assign opb_ctrl.kind      = const_kind_e'(const_sel);

    vsp_shuffle #(.NLANES(NLANES), .EW(EW)) u_shuffle (
        .in_data  (a_data),
        .in_none  (a_none),
        .idx      (idx),
        .out_data (shuf_data),
        .out_none (shuf_none)
    );

    vsp_operand_b #(.NLANES(NLANES), .EW(EW)) u_opb (
        .ctrl     (opb_ctrl),
        .b_data   (b_data),
        .b_none   (b_none),
        .op_data  (opb_data),
        .op_none  (opb_none)
    );

    vsp_pick #(.NLANES(NLANES), .EW(EW)) u_pick (
        .mask     (mask),
        .x_data   (shuf_data),
        .x_none   (shuf_none),
        .y_data   (opb_data),
        .y_none   (opb_none),
        .out_data (pick_data),
        .out_none (pick_none)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data  <= '0;
            res_none  <= '1;
            res_valid <= 1'b0;
        end else begin
            res_valid <= issue;
            if (issue) begin
                res_data <= pick_data;
                res_none <= pick_none;
            end
        end
    end

    AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        issue |=> res_valid);                                               // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !issue |=> ($stable(res_data) && $stable(res_none) && !res_valid)); // R8
    AST_RESET_ALL_NONE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((&res_none) && (res_data == '0) && !res_valid));     // R9
    AST_NO_NONE_CREATED: assert property (@(posedge clk) disable iff (rst)
        (issue && (a_none == '0) && !use_const && (b_none == '0))
            |=> (res_none == '0));                                          // R3
    AST_CONST_NONE_FILL: assert property (@(posedge clk) disable iff (rst)
        (issue && (mask == '0) && use_const && (const_sel == 2'd3))
            |=> ((&res_none) && (res_data == '0)));                          // R6
    AST_MASK_ALL_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (issue && (&mask) && (a_none == '0)) |=> (res_none == '0));          // R4

endmodule

// File: tb/vsp_unit_bench.sv
`timescale 1ns/1ps
module vsp_unit_bench;

    localparam int NL = 4;
    localparam int W  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [31:0] a_data = '0;
    logic [3:0]  a_none = '0;
    logic [7:0]  idx = '0;
    logic [3:0]  mask = '0;
    logic [31:0] b_data = '0;
    logic [3:0]  b_none = '0;
    logic        use_const = 1'b0;
    logic [1:0]  const_sel = '0;
    logic [31:0] res_data;
    logic [3:0]  res_none;
    logic        res_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    vsp_unit #(.NLANES(NL), .EW(W)) u_vsp_unit (
        .clk(clk), .rst(rst), .issue(issue),
        .a_data(a_data), .a_none(a_none), .idx(idx), .mask(mask),
        .b_data(b_data), .b_none(b_none),
        .use_const(use_const), .const_sel(const_sel),
        .res_data(res_data), .res_none(res_none), .res_valid(res_valid)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] a;
        logic [3:0]  an;
        logic [7:0]  ix;
        logic [3:0]  m;
        logic [31:0] b;
        logic [3:0]  bn;
        logic        uc;
        logic [1:0]  cs;
        logic [31:0] ed;
        logic [3:0]  en;
    } vec_t;

    // Lane 0 is the low byte; idx lane 0 is bits [1:0].
    localparam vec_t TBL [9] = '{
        // R1 identity order
        '{4'd1, 32'h44332211, 4'h0, 8'hE4, 4'hF, 32'hDDCCBBAA, 4'h0, 1'b0, 2'd0, 32'h44332211, 4'h0},
        // R1 reversed order
        '{4'd1, 32'h44332211, 4'h0, 8'h1B, 4'hF, 32'hDDCCBBAA, 4'h0, 1'b0, 2'd0, 32'h11223344, 4'h0},
        // R2 every lane copies source lane 2
        '{4'd2, 32'h44332211, 4'h0, 8'hAA, 4'hF, 32'hDDCCBBAA, 4'h0, 1'b0, 2'd0, 32'h33333333, 4'h0},
        // R4 and R5 alternating mask against operand b
        '{4'd5, 32'h44332211, 4'h0, 8'hE4, 4'h5, 32'hDDCCBBAA, 4'h8, 1'b0, 2'd0, 32'hDD33BB11, 4'h8},
        // R6 zero constant under a reversed source
        '{4'd6, 32'h44332211, 4'h0, 8'h1B, 4'h3, 32'hDDCCBBAA, 4'hF, 1'b1, 2'd0, 32'h00003344, 4'h0},
        // R6 None constant, operand b ignored
        '{4'd6, 32'h44332211, 4'h0, 8'h00, 4'hA, 32'hDDCCBBAA, 4'hF, 1'b1, 2'd3, 32'h11001100, 4'h5},
        // R6 minus one constant
        '{4'd6, 32'h44332211, 4'h0, 8'hE4, 4'h1, 32'hDDCCBBAA, 4'h0, 1'b1, 2'd2, 32'hFFFFFF11, 4'h0},
        // R6 one constant in every lane
        '{4'd6, 32'h44332211, 4'h0, 8'hE4, 4'h0, 32'hDDCCBBAA, 4'h0, 1'b1, 2'd1, 32'h01010101, 4'h0},
        // R3 None lane 1 duplicated keeps its flag
        '{4'd3, 32'h44332211, 4'h2, 8'h55, 4'hF, 32'hDDCCBBAA, 4'h0, 1'b0, 2'd0, 32'h22222222, 4'hF}
    };

    task automatic check(input string tag, input logic [31:0] got_d, input logic [3:0] got_n,
                         input logic got_v, input logic [31:0] exp_d, input logic [3:0] exp_n,
                         input logic exp_v);
        n_checks++;
        if (got_d !== exp_d || got_n !== exp_n || got_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got data=%h none=%b valid=%b, expected data=%h none=%b valid=%b",
                     tag, got_d, got_n, got_v, exp_d, exp_n, exp_v);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        a_data = v.a; a_none = v.an; idx = v.ix; mask = v.m;
        b_data = v.b; b_none = v.bn; use_const = v.uc; const_sel = v.cs;
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 reset", res_data, res_none, res_valid, 32'h0, 4'hF, 1'b0);

        for (int i = 0; i < 9; i++) begin
            apply(TBL[i]);
            check($sformatf("R%0d table row %0d", TBL[i].req, i),
                  res_data, res_none, res_valid, TBL[i].ed, TBL[i].en, 1'b1);
        end

        // R7 valid pulse lasts one cycle, result stays
        @(negedge clk);
        check("R7 valid drops", res_data, res_none, res_valid, 32'h22222222, 4'hF, 1'b0);

        // R8 inputs change without issue: no effect
        a_data = 32'h99887766; a_none = 4'h0; mask = 4'h0;
        use_const = 1'b1; const_sel = 2'd0;
        repeat (3) @(negedge clk);
        check("R8 hold", res_data, res_none, res_valid, 32'h22222222, 4'hF, 1'b0);

        // R7 new issue updates after one edge
        apply('{4'd7, 32'h44332211, 4'h0, 8'h1B, 4'hF, 32'h0, 4'h0, 1'b0, 2'd0, 32'h0, 4'h0});
        check("R7 load", res_data, res_none, res_valid, 32'h11223344, 4'h0, 1'b1);

        // R5 operand b None flags pass when mask is zero
        apply('{4'd5, 32'h44332211, 4'h0, 8'hE4, 4'h0, 32'h0A0B0C0D, 4'h6, 1'b0, 2'd0, 32'h0, 4'h0});
        check("R5 operand b", res_data, res_none, res_valid, 32'h0A0B0C0D, 4'h6, 1'b1);

        // R9 reset after a load
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset after load", res_data, res_none, res_valid, 32'h0, 4'hF, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule